// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the memory-mapped register file of a core-local interrupt controller that serves a configurable number of sources (`NSRC`, at most 4096). It sits on a simple synchronous bus with an access strobe, a write flag, an access size (byte, half-word or word), a 16-bit address, write data and read data. Read data is combinational in the access cycle, and writes take effect at the next rising clock edge.

The bank holds a global configuration byte, a read-only information word and a threshold byte. For every source it has four byte registers: pending, enable, attribute and control. The enable, trigger mode, vectored flag, control byte and level-width field are driven continuously to the arbiter. The pending bit is owned by separate per-source pending logic. This bank only reads that bit back, and it forwards software writes to it as one-cycle strobes so that the pending logic can apply its own trigger-dependent rules.

Top module: `intc_regbank`

## Requirements
- R1: Byte address map: configuration at 0x0000, information word at 0x0004–0x0007, threshold at 0x000B, and for source i the pending, enable, attribute and control bytes at 0x1000+4i+0, +1, +2, +3. The byte at address a is carried on data bits 8*(a mod 4)+7 down to 8*(a mod 4). Byte lanes that are not part of the access read as zero.
- R2: Configuration byte: bits 4:1 form a writable level-width field that resets to 0 and is driven on `lvlw_o`. Bits 7:5 read 0 and bit 0 reads 1.
- R3: Information word = {7'b0, CTLBITS[3:0] in 24:21, VERSION in 20:13, NSRC in 12:0}. Writes to it change nothing.
- R4: Threshold byte: all 8 bits are writable, it resets to 0, and it is driven on `thresh_o`.
- R5: Enable byte: bit 0 is writable, resets to 0 and is driven on `ie_o[i]`. Bits 7:1 read 0.
- R6: Attribute byte: bits 7:6 read 2'b11 and bits 5:3 read 0. Bits 2:1 (trigger mode, on `trig_o[2i+1:2i]`) and bit 0 (vectored flag, on `vec_o[i]`) are writable and reset to 0.
- R7: Control byte: only its upper CTLBITS bits are storage (reset 0), and its low 8-CTLBITS bits always read 1. The full byte is driven on `ctl_o[8i+7:8i]`.
- R8: Pending byte: bit 0 reads `src_ip_i[i]` and bits 7:1 read 0. A write that covers it raises `ip_wr_o[i]` combinationally in that access cycle only, with `ip_wdata_o[i]` equal to write-data bit 0.
- R9: A word write at 0x1000+4i updates the pending, enable, attribute and control bytes of source i in the same cycle, each under its own rules.
- R10: Size encoding is 0 = byte, 1 = half-word, 2 = word, 3 = reserved. A reserved size, a half-word at an odd address or a word at an address not a multiple of 4 is misaligned. Such an access reads all zero and changes no state.
- R11: Source locations at index NSRC or above, and every address not listed in R1, read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size (R10 encoding) |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Read data, lane-aligned |
| src_ip_i | input | NSRC | Pending bits from the pending logic |
| lvlw_o | output | 4 | Level-width field |
| thresh_o | output | 8 | Threshold level |
| ie_o | output | NSRC | Enable bits |
| trig_o | output | 2*NSRC | Trigger mode, 2 bits per source |
| vec_o | output | NSRC | Vectored flags |
| ctl_o | output | 8*NSRC | Control bytes including the forced-one bits |
| ip_wr_o | output | NSRC | Pending-write strobes |
| ip_wdata_o | output | NSRC | Value written to the pending bit |

## Verification
Directed accesses first walk every global location and the four bytes of chosen sources at each size. All-ones and alternating write patterns show which bits are storage, which are forced to zero and which are forced to one. Word writes against byte and half-word writes to the same source separate lane decoding from per-byte rules. Changing `src_ip_i` patterns while reading the pending bytes shows that the bit is a live view and not a stored copy. Misaligned, reserved-size, beyond-NSRC and unmapped accesses, followed by a long stream of random accesses, separate real decode hits from aliases.

// File: rtl/intc_regbank_pkg.sv
package intc_regbank_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [13:0] SRC_BASE_WORD = 14'h400;

  // Lane mask of an access; all zero when the access is misaligned.
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] a);
    logic [3:0] m;
    case (size)
      SZ_BYTE: m = 4'b0001 << a;
      SZ_HALF: m = a[0] ? 4'b0000 : (a[1] ? 4'b1100 : 4'b0011);
      SZ_WORD: m = (a == 2'd0) ? 4'b1111 : 4'b0000;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  // Bits of a control byte that are forced to one.
  function automatic logic [7:0] ctl_fill(input int ctlbits);
    return 8'hFF >> ctlbits;
  endfunction

endpackage

// File: rtl/intc_bus_dec.sv
module intc_bus_dec
  import intc_regbank_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            sel,
  input  logic            we,
  input  logic [1:0]      size,
  input  logic [15:0]     addr,
  output logic [3:0]      be,
  output logic            acc_wr,
  output logic            hit_cfg,
  output logic            hit_info,
  output logic            hit_thr,
  output logic            hit_src,
  output logic [IDXW-1:0] src_idx
);
  logic [13:0] wa;
  logic [13:0] src_off;

  assign wa       = addr[15:2];
  assign be       = lane_mask(size, addr[1:0]);
  assign acc_wr   = sel & we & (|be);
  assign hit_cfg  = (wa == 14'd0);
  assign hit_info = (wa == 14'd1);
  assign hit_thr  = (wa == 14'd2);
  assign src_off  = wa - SRC_BASE_WORD;
  assign hit_src  = (wa >= SRC_BASE_WORD) && (32'(src_off) < NSRC);
  assign src_idx  = src_off[IDXW-1:0];
endmodule

// File: rtl/intc_src_slot.sv
module intc_src_slot
  import intc_regbank_pkg::*;
#(
  parameter int CTLBITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] be,
  input  logic       ip_bit,
  input  logic       ie_bit,
  input  logic [2:0] attr_bits,
  input  logic [7:0] ctl_byte,
  output logic       ie,
  output logic [1:0] trig,
  output logic       vec,
  output logic [7:0] ctl,
  output logic       ip_wr,
  output logic       ip_val
);
  localparam logic [7:0] LOW_ONES = ctl_fill(CTLBITS);

  logic [7:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      trig  <= 2'b00;
      vec   <= 1'b0;
      ctl_q <= 8'h00;
    end else if (wr_en) begin
      if (be[1]) ie <= ie_bit;
      if (be[2]) begin
        trig <= attr_bits[2:1];
        vec  <= attr_bits[0];
      end
      if (be[3]) ctl_q <= ctl_byte & ~LOW_ONES;
    end
  end

  assign ctl    = ctl_q | LOW_ONES;
  assign ip_wr  = wr_en & be[0];
  assign ip_val = ip_bit;
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_regbank_pkg::*;
#(
  parameter int          NSRC    = 8,
  parameter int          CTLBITS = 6,
  parameter logic [7:0]  VERSION = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [1:0]           bus_size,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NSRC-1:0]      src_ip_i,
  output logic [3:0]           lvlw_o,
  output logic [7:0]           thresh_o,
  output logic [NSRC-1:0]      ie_o,
  output logic [2*NSRC-1:0]    trig_o,
  output logic [NSRC-1:0]      vec_o,
  output logic [8*NSRC-1:0]    ctl_o,
  output logic [NSRC-1:0]      ip_wr_o,
  output logic [NSRC-1:0]      ip_wdata_o
);
  localparam int          IDXW      = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [31:0] INFO_WORD = {7'd0, 4'(CTLBITS), VERSION, 13'(NSRC)};

  logic [3:0]      be;
  logic            acc_wr, hit_cfg, hit_info, hit_thr, hit_src;
  logic [IDXW-1:0] src_idx;
  logic            cfg_wr, thr_wr;
  logic [3:0]      lvl_q;
  logic [7:0]      thr_q;
  logic [7:0]      ctl_a [NSRC];
  logic [NSRC-1:0] slot_wr;
  logic [31:0]     rd_word;
  logic            unused_wbits;

  intc_bus_dec #(.NSRC(NSRC)) u_dec (
    .sel(bus_sel), .we(bus_we), .size(bus_size), .addr(bus_addr),
    .be(be), .acc_wr(acc_wr), .hit_cfg(hit_cfg), .hit_info(hit_info),
    .hit_thr(hit_thr), .hit_src(hit_src), .src_idx(src_idx)
  );

  // Named write events for the checker
  assign cfg_wr = acc_wr & hit_cfg & be[0];
  assign thr_wr = acc_wr & hit_thr & be[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 4'd0;
      thr_q <= 8'd0;
    end else begin
      if (cfg_wr) lvl_q <= bus_wdata[4:1];
      if (thr_wr) thr_q <= bus_wdata[31:24];
    end
  end

  assign lvlw_o   = lvl_q;
  assign thresh_o = thr_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign slot_wr[g] = acc_wr & hit_src & (src_idx == IDXW'(g));
    intc_src_slot #(.CTLBITS(CTLBITS)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(slot_wr[g]), .be(be),
      .ip_bit(bus_wdata[0]), .ie_bit(bus_wdata[8]),
      .attr_bits(bus_wdata[18:16]), .ctl_byte(bus_wdata[31:24]),
      .ie(ie_o[g]), .trig(trig_o[2*g +: 2]), .vec(vec_o[g]),
      .ctl(ctl_a[g]), .ip_wr(ip_wr_o[g]), .ip_val(ip_wdata_o[g])
    );
    assign ctl_o[8*g +: 8] = ctl_a[g];
  end

  always_comb begin
    rd_word = 32'd0;
    if (hit_cfg)       rd_word[7:0] = {3'b000, lvl_q, 1'b1};
    else if (hit_info) rd_word      = INFO_WORD;
    else if (hit_thr)  rd_word[31:24] = thr_q;
    else if (hit_src)  rd_word = {ctl_a[src_idx],
                                  2'b11, 3'b000, trig_o[{src_idx, 1'b0} +: 2], vec_o[src_idx],
                                  7'd0, ie_o[src_idx],
                                  7'd0, src_ip_i[src_idx]};
  end

  assign bus_rdata = bus_sel ? (rd_word & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}}) : 32'd0;

  assign unused_wbits = ^{bus_wdata[23:19], bus_wdata[15:9], bus_wdata[7:5]};
endmodule

// File: rtl/intc_regbank_chk.sv
module intc_regbank_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [1:0]      bus_size,
  input logic [15:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [3:0]      lvlw_o,
  input logic [7:0]      thresh_o,
  input logic [NSRC-1:0] ip_wr_o
);
  logic misal;
  logic beyond;

  assign misal  = (bus_size == 2'd3) ||
                  (bus_size == 2'd1 && bus_addr[0]) ||
                  (bus_size == 2'd2 && bus_addr[1:0] != 2'd0);
  assign beyond = (32'(bus_addr) >= 32'h1000 + 4 * NSRC);

  // R10
  misal_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && misal) |-> (bus_rdata == 32'd0));

  // R10
  misal_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && misal) |=> ($stable(thresh_o) && $stable(lvlw_o)));

  // R8
  ip_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ip_wr_o));

  // R8
  ip_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_wr_o != '0) |-> (bus_sel && bus_we && !misal && bus_addr[1:0] == 2'd0));

  // R4
  thr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thresh_o) |-> $past(bus_sel && bus_we && bus_addr[15:2] == 14'd2));

  // R2
  lvl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvlw_o) |-> $past(bus_sel && bus_we && bus_addr[15:2] == 14'd0));

  // R11
  beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && beyond) |-> (bus_rdata == 32'd0));
endmodule

bind intc_regbank intc_regbank_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .lvlw_o(lvlw_o), .thresh_o(thresh_o), .ip_wr_o(ip_wr_o)
);

// File: tb/test_intc_regbank.sv
module test_intc_regbank;
  localparam int         NSRC    = 8;
  localparam int         CTLBITS = 6;
  localparam logic [7:0] VERSION = 8'h21;
  localparam logic [31:0] INFO  = (CTLBITS << 21) | (VERSION << 13) | NSRC;
  localparam int         LOWM    = 255 >> CTLBITS;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NSRC-1:0] src_ip_i = 0;
  logic [3:0] lvlw_o;
  logic [7:0] thresh_o;
  logic [NSRC-1:0] ie_o, vec_o, ip_wr_o, ip_wdata_o;
  logic [2*NSRC-1:0] trig_o;
  logic [8*NSRC-1:0] ctl_o;

  int n_chk = 0, n_fail = 0;
  bit live = 0;

  // reference state
  int m_nl = 0, m_thr = 0;
  int m_ie[NSRC], m_attr[NSRC], m_ctl[NSRC];

  always #2 clk = ~clk;

  intc_regbank #(.NSRC(NSRC), .CTLBITS(CTLBITS), .VERSION(VERSION)) i_intc_regbank (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit misal(input int sz, input int a);
    return (sz == 3) || (a % (1 << sz) != 0);
  endfunction

  function automatic int m_byte(input int a);
    int off, i;
    if (a == 0) return (m_nl << 1) | 1;
    if (a >= 4 && a <= 7) return (INFO >> (8 * (a - 4))) & 255;
    if (a == 11) return m_thr;
    if (a < 'h1000) return 0;
    off = a - 'h1000; i = off / 4;
    if (i >= NSRC) return 0;
    case (off % 4)
      0: return int'(src_ip_i[i]);
      1: return m_ie[i];
      2: return 'hC0 | m_attr[i];
      default: return m_ctl[i] | LOWM;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int sz, input int a);
    logic [31:0] r = 0;
    if (misal(sz, a)) return 0;
    for (int k = 0; k < (1 << sz); k++) r |= 32'(m_byte(a + k)) << (8 * ((a + k) % 4));
    return r;
  endfunction

  task automatic m_write(input int sz, input int a, input logic [31:0] d);
    if (misal(sz, a)) return;
    for (int k = 0; k < (1 << sz); k++) begin
      int b, v, off, i;
      b = a + k; v = int'((d >> (8 * (b % 4))) & 32'hFF);
      if (b == 0) m_nl = (v >> 1) & 15;
      else if (b == 11) m_thr = v;
      else if (b >= 'h1000) begin
        off = b - 'h1000; i = off / 4;
        if (i < NSRC) case (off % 4)
          1: m_ie[i] = v & 1;
          2: m_attr[i] = v & 7;
          3: m_ctl[i] = v & ~LOWM & 255;
          default: ;
        endcase
      end
    end
  endtask

  function automatic string tag_of(input int sz, input int a);
    int off;
    if (misal(sz, a)) return "R10";
    if (a < 4) return "R2";
    if (a < 8) return "R3";
    if (a < 12) return "R4";
    if (a < 'h1000 || (a - 'h1000) / 4 >= NSRC) return "R11";
    if (sz != 0) return "R1";
    off = (a - 'h1000) % 4;
    case (off) 0: return "R8"; 1: return "R5"; 2: return "R6"; default: return "R7"; endcase
  endfunction

  task automatic acc(input bit we, input int sz, input int a, input logic [31:0] d, input string tag);
    logic [NSRC-1:0] ewr;
    string t;
    int i;
    t = (tag == "") ? tag_of(sz, a) : tag;
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_size = 2'(sz); bus_addr = 16'(a); bus_wdata = d;
    #1;
    chk(bus_rdata == m_read(sz, a), t, 64'(bus_rdata), 64'(m_read(sz, a)));
    ewr = 0;
    i = (a - 'h1000) / 4;
    if (we && !misal(sz, a) && a >= 'h1000 && a % 4 == 0 && i < NSRC) ewr[i] = 1;
    chk(ip_wr_o == ewr, "R8 strobe", 64'(ip_wr_o), 64'(ewr));
    if (ewr != 0) chk(ip_wdata_o[i] == d[0], "R8 value", 64'(ip_wdata_o[i]), 64'(d[0]));
    @(posedge clk);
    if (we) m_write(sz, a, d);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  // state comparison every clock
  always @(negedge clk) if (live) begin
    chk(int'(lvlw_o) == m_nl, "R2 lvlw", 64'(lvlw_o), 64'(m_nl));
    chk(int'(thresh_o) == m_thr, "R4 thresh", 64'(thresh_o), 64'(m_thr));
    for (int i = 0; i < NSRC; i++) begin
      chk(int'(ie_o[i]) == m_ie[i], "R5 ie", 64'(ie_o[i]), 64'(m_ie[i]));
      chk(int'({trig_o[2*i +: 2], vec_o[i]}) == m_attr[i], "R6 attr", 64'({trig_o[2*i +: 2], vec_o[i]}), 64'(m_attr[i]));
      chk(int'(ctl_o[8*i +: 8]) == (m_ctl[i] | LOWM), "R7 ctl", 64'(ctl_o[8*i +: 8]), 64'(m_ctl[i] | LOWM));
    end
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin m_ie[i] = 0; m_attr[i] = 0; m_ctl[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; live = 1;
    // reset state
    acc(0, 0, 0, 0, "R2 reset");
    acc(0, 2, 4, 0, "R3 reset");
    acc(0, 0, 11, 0, "R4 reset");
    for (int i = 0; i < NSRC; i++) acc(0, 2, 'h1000 + 4 * i, 0, "R1 reset");
    // configuration byte
    acc(1, 0, 0, 32'hFF, "R2"); acc(0, 0, 0, 0, "R2");
    acc(1, 2, 0, 32'hFFFF_FF0A, "R2"); acc(0, 1, 0, 0, "R2");
    // information word
    acc(1, 2, 4, 32'hFFFF_FFFF, "R3"); acc(0, 2, 4, 0, "R3"); acc(0, 0, 6, 0, "R3");
    // threshold
    acc(1, 1, 10, 32'hAB00_0000, "R4"); acc(0, 2, 8, 0, "R4");
    acc(1, 0, 11, 32'h5A00_0000, "R4"); acc(0, 0, 11, 0, "R4");
    // word write to one source
    acc(1, 2, 'h100C, 32'hFFFF_FFFF, "R9"); acc(0, 2, 'h100C, 0, "R9");
    acc(1, 2, 'h101C, 32'hA5A5_A5A5, "R9"); acc(0, 2, 'h101C, 0, "R9");
    // byte and half-word writes
    acc(1, 0, 'h1001, 32'h0000_0100, "R5"); acc(0, 0, 'h1001, 0, "R5");
    acc(1, 0, 'h1002, 32'h00FA_0000, "R6"); acc(0, 0, 'h1002, 0, "R6");
    acc(1, 0, 'h1003, 32'h5500_0000, "R7"); acc(0, 0, 'h1003, 0, "R7");
    acc(1, 1, 'h1016, 32'hFF07_0000, "R1"); acc(0, 2, 'h1014, 0, "R1");
    acc(1, 0, 'h1008, 32'h0000_0001, "R8");
    // pending bit reads with changing patterns
    src_ip_i = 8'hA5;
    for (int i = 0; i < NSRC; i++) acc(0, 0, 'h1000 + 4 * i, 0, "R8");
    src_ip_i = 8'h5A;
    for (int i = 0; i < NSRC; i++) acc(0, 1, 'h1000 + 4 * i, 0, "R8");
    // misaligned accesses
    acc(1, 2, 9, 32'hFFFF_FFFF, "R10"); acc(0, 0, 11, 0, "R10");
    acc(1, 1, 'h1001, 32'hFFFF_FFFF, "R10"); acc(1, 2, 'h1002, 32'hFFFF_FFFF, "R10");
    acc(1, 3, 'h1000, 32'hFFFF_FFFF, "R10"); acc(0, 3, 0, 0, "R10");
    acc(1, 1, 1, 32'hFFFF_FFFF, "R10"); acc(0, 0, 0, 0, "R10");
    // beyond NSRC and unmapped
    acc(1, 2, 'h1000 + 4 * NSRC, 32'hFFFF_FFFF, "R11"); acc(0, 2, 'h1000 + 4 * NSRC, 0, "R11");
    acc(1, 2, 12, 32'hFFFF_FFFF, "R11"); acc(0, 2, 12, 0, "R11");
    acc(0, 2, 'h0FFC, 0, "R11"); acc(0, 2, 'hFFFC, 0, "R11"); acc(0, 2, 'h8000, 0, "R11");
    // random traffic
    for (int n = 0; n < 600; n++) begin
      int a, sz;
      a  = ($urandom % 3 == 0) ? int'($urandom % 16) : 'h1000 + int'($urandom % (4 * NSRC + 8));
      sz = int'($urandom % 4);
      src_ip_i = NSRC'($urandom);
      acc(bit'($urandom % 2), sz, a, $urandom, "");
    end
    live = 0;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule